// File: doc/BRIEF.md
# In-Order Retire Controller with Squash Undo

This block is the last stage of a pipelined core. Two instruction queues feed it: one filled straight by decode and one filled by the stage that resolves indirect addresses. Each cycle it looks at the head of both queues. A head whose generation tag is out of date is thrown away. If that squashed instruction had already bumped a pointer in memory, the block sends a compensating write that puts the old pointer value back. Otherwise the head whose sequence number equals the running retire count is the one chosen. It waits for its operand line if it needs one and then hands its PC and operand to an outside execution port. That port returns the next PC, whether a control register was written, and any store data.

When a retirement redirects the flow, or an interrupt or I/O event is seen, the block pulses a restart that carries the new PC. That pulse also tells the owner of the global generation counter to advance. The local generation is aligned to match. All memory traffic leaves as single-word masked writes through one registered command port.

Top module: `retire_ctl`

## Requirements
- R1: While `halted` is 1 no queue head is popped, no response is consumed, no command is issued and `retire_cnt` does not change.
- R2: A head retires only when its sequence number equals `retire_cnt`. When both heads qualify, the decode-queue head (`dq_*`) retires and the indirect-queue head stays.
- R3: A valid head whose generation differs from both the local generation and `glob_gen` is stale. It is popped without executing. At most one head is dropped per cycle, the decode head is dropped first, and a drop takes the place of any retirement in that cycle.
- R4: When a dropped stale head has its autoincrement flag set, the next cycle carries a command with `cmd_addr` equal to its pointer address and `cmd_data` equal to (low 12 bits of its final address − 1) mod 4096.
- R5: A chosen head that needs an operand does not retire until `resp_valid` is 1. Any response seen then is consumed (`resp_pop`). It retires only if `resp_line` equals the final address shifted right by 3. The operand is then word *k* of `resp_data`, where *k* is the final address bits [2:0] and word *k* sits at bits [12k+11:12k]. A mismatched response is dropped with no retirement.
- R6: A retiring head with its store flag set produces, one cycle later, a command at its final address carrying `ex_store_data`.
- R7: A restart pulse (`redir_valid`) follows one cycle after any of these: a retirement whose `ex_next_pc` differs from the head's sequential PC, a retirement with `ex_ctl_wr`, or `ext_irq`/`ext_ctl_chg` in a cycle that retires or is halted. It carries the updated PC, and `redir_irq` is set only when `ext_irq` caused it.
- R8: After a restart the local generation becomes `glob_gen`+1. A retiring head whose generation differs from the local generation makes the local generation equal to `glob_gen`.
- R9: `retire_cnt` resets to 0 and increases by exactly one per retirement.
- R10: While `cmd_ready` is 0 no head is popped, no response is consumed and no command is issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halted | input | 1 | Architectural halt bit |
| cmd_ready | input | 1 | Memory command port can accept |
| glob_gen | input | 4 | Global generation count |
| dq_valid | input | 1 | Decode queue head present |
| dq_gen | input | 4 | Decode head generation |
| dq_seq | input | 16 | Decode head sequence number |
| dq_pc | input | 15 | Decode head PC |
| dq_seq_pc | input | 15 | Decode head sequential next PC |
| dq_load | input | 1 | Decode head needs operand |
| dq_store | input | 1 | Decode head stores |
| dq_autoinc | input | 1 | Decode head autoincremented a pointer |
| dq_fin | input | 15 | Decode head final address |
| dq_ptr | input | 15 | Decode head pointer address |
| dq_pop | output | 1 | Decode head consumed |
| iq_valid | input | 1 | Indirect queue head present |
| iq_gen | input | 4 | Indirect head generation |
| iq_seq | input | 16 | Indirect head sequence number |
| iq_pc | input | 15 | Indirect head PC |
| iq_seq_pc | input | 15 | Indirect head sequential next PC |
| iq_load | input | 1 | Indirect head needs operand |
| iq_store | input | 1 | Indirect head stores |
| iq_autoinc | input | 1 | Indirect head autoincremented a pointer |
| iq_fin | input | 15 | Indirect head final address |
| iq_ptr | input | 15 | Indirect head pointer address |
| iq_pop | output | 1 | Indirect head consumed |
| resp_valid | input | 1 | Operand line response present |
| resp_line | input | 12 | Line address of response |
| resp_data | input | 96 | Eight 12-bit words of the line |
| resp_pop | output | 1 | Response consumed |
| ex_valid | output | 1 | Instruction retires this cycle |
| ex_pc | output | 15 | PC of retiring instruction |
| ex_operand | output | 12 | Loaded operand (0 if none) |
| ex_next_pc | input | 15 | Next PC from execution port |
| ex_ctl_wr | input | 1 | Execution wrote a control register |
| ex_store_data | input | 12 | Store data from execution port |
| ext_irq | input | 1 | Interrupt taken |
| ext_ctl_chg | input | 1 | I/O changed control registers |
| cmd_valid | output | 1 | Write command valid |
| cmd_addr | output | 15 | Write word address |
| cmd_data | output | 12 | Write data |
| redir_valid | output | 1 | Restart / generation bump pulse |
| redir_pc | output | 15 | Restart PC |
| redir_irq | output | 1 | Restart caused by interrupt |
| retire_cnt | output | 16 | Retire count |

## Verification
Pops, `resp_pop`, `ex_valid`, `ex_pc` and `ex_operand` are decided in the same cycle as the heads and response they depend on. The bench compares them a moment after it drives its inputs, before the next rising edge. Write commands, restart pulses and the retire count sit one register behind, so they are due after the next rising edge. The bench's model holds those expected values for one cycle and compares them at the following falling edge, just before new inputs go in. Stimulus is weighted so that stale heads, generation adoption, mismatched lines, halts and stalled command cycles each come up many times.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_UNDO0 = 2'd1,
    SRC_UNDO1 = 2'd2,
    SRC_STORE = 2'd3
  } cmd_src_e;
endpackage

// File: rtl/rc_head_check.sv
module rc_head_check #(
  parameter int GEN_W = 4,
  parameter int SEQ_W = 16
) (
  input  logic             valid,
  input  logic [GEN_W-1:0] gen,
  input  logic [SEQ_W-1:0] seq,
  input  logic [GEN_W-1:0] loc_gen,
  input  logic [GEN_W-1:0] glob_gen,
  input  logic [SEQ_W-1:0] cnt,
  output logic             stale,
  output logic             elig
);
  always_comb begin
    stale = valid && (gen != loc_gen) && (gen != glob_gen);
    elig  = valid && !stale && (seq == cnt);
  end
endmodule

// File: rtl/rc_operand.sv
module rc_operand #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int OFF_W  = 3,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int WORDS  = 1 << OFF_W
) (
  input  logic [ADDR_W-1:0]       fin,
  input  logic [LINE_W-1:0]       resp_line,
  input  logic [WORDS*DATA_W-1:0] resp_data,
  output logic                    hit,
  output logic [DATA_W-1:0]       word
);
  logic [DATA_W-1:0] w [WORDS];
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    assign w[k] = resp_data[k*DATA_W +: DATA_W];
  end
  assign hit  = (resp_line == fin[ADDR_W-1:OFF_W]);
  assign word = w[fin[OFF_W-1:0]];
endmodule

// File: rtl/rc_cmd_out.sv
module rc_cmd_out #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= wr_en;
      if (wr_en) begin
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/retire_ctl.sv
module retire_ctl
  import retire_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int GEN_W  = 4,
  parameter int SEQ_W  = 16,
  parameter int OFF_W  = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = 'h80,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int WORDS  = 1 << OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    halted,
  input  logic                    cmd_ready,
  input  logic [GEN_W-1:0]        glob_gen,
  input  logic                    dq_valid,
  input  logic [GEN_W-1:0]        dq_gen,
  input  logic [SEQ_W-1:0]        dq_seq,
  input  logic [ADDR_W-1:0]       dq_pc,
  input  logic [ADDR_W-1:0]       dq_seq_pc,
  input  logic                    dq_load,
  input  logic                    dq_store,
  input  logic                    dq_autoinc,
  input  logic [ADDR_W-1:0]       dq_fin,
  input  logic [ADDR_W-1:0]       dq_ptr,
  output logic                    dq_pop,
  input  logic                    iq_valid,
  input  logic [GEN_W-1:0]        iq_gen,
  input  logic [SEQ_W-1:0]        iq_seq,
  input  logic [ADDR_W-1:0]       iq_pc,
  input  logic [ADDR_W-1:0]       iq_seq_pc,
  input  logic                    iq_load,
  input  logic                    iq_store,
  input  logic                    iq_autoinc,
  input  logic [ADDR_W-1:0]       iq_fin,
  input  logic [ADDR_W-1:0]       iq_ptr,
  output logic                    iq_pop,
  input  logic                    resp_valid,
  input  logic [LINE_W-1:0]       resp_line,
  input  logic [WORDS*DATA_W-1:0] resp_data,
  output logic                    resp_pop,
  output logic                    ex_valid,
  output logic [ADDR_W-1:0]       ex_pc,
  output logic [DATA_W-1:0]       ex_operand,
  input  logic [ADDR_W-1:0]       ex_next_pc,
  input  logic                    ex_ctl_wr,
  input  logic [DATA_W-1:0]       ex_store_data,
  input  logic                    ext_irq,
  input  logic                    ext_ctl_chg,
  output logic                    cmd_valid,
  output logic [ADDR_W-1:0]       cmd_addr,
  output logic [DATA_W-1:0]       cmd_data,
  output logic                    redir_valid,
  output logic [ADDR_W-1:0]       redir_pc,
  output logic                    redir_irq,
  output logic [SEQ_W-1:0]        retire_cnt
);
  localparam int NQ = 2;

  logic [SEQ_W-1:0]  cnt_q;
  logic [GEN_W-1:0]  lgen_q;
  logic [ADDR_W-1:0] pc_q;

  logic              h_valid [NQ];
  logic [GEN_W-1:0]  h_gen   [NQ];
  logic [SEQ_W-1:0]  h_seq   [NQ];
  logic [ADDR_W-1:0] h_pc    [NQ];
  logic [ADDR_W-1:0] h_spc   [NQ];
  logic              h_load  [NQ];
  logic              h_store [NQ];
  logic              h_auto  [NQ];
  logic [ADDR_W-1:0] h_fin   [NQ];
  logic [ADDR_W-1:0] h_ptr   [NQ];
  logic [NQ-1:0]     stale, elig;

  assign h_valid = '{dq_valid, iq_valid};
  assign h_gen   = '{dq_gen, iq_gen};
  assign h_seq   = '{dq_seq, iq_seq};
  assign h_pc    = '{dq_pc, iq_pc};
  assign h_spc   = '{dq_seq_pc, iq_seq_pc};
  assign h_load  = '{dq_load, iq_load};
  assign h_store = '{dq_store, iq_store};
  assign h_auto  = '{dq_autoinc, iq_autoinc};
  assign h_fin   = '{dq_fin, iq_fin};
  assign h_ptr   = '{dq_ptr, iq_ptr};

  for (genvar q = 0; q < NQ; q++) begin : g_head
    rc_head_check #(.GEN_W(GEN_W), .SEQ_W(SEQ_W)) u_chk (
      .valid(h_valid[q]), .gen(h_gen[q]), .seq(h_seq[q]),
      .loc_gen(lgen_q), .glob_gen(glob_gen), .cnt(cnt_q),
      .stale(stale[q]), .elig(elig[q])
    );
  end

  logic              sel;
  logic              work, want, retire, drop_d, drop_i;
  logic              opnd_hit;
  logic [DATA_W-1:0] opnd_word;
  logic              ext_ev, restart, adopt;
  logic [ADDR_W-1:0] new_pc;
  cmd_src_e          src;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign sel = !elig[0];

  rc_operand #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_opnd (
    .fin(h_fin[sel]), .resp_line(resp_line), .resp_data(resp_data),
    .hit(opnd_hit), .word(opnd_word)
  );

  always_comb begin
    work     = cmd_ready && !halted;
    drop_d   = work && stale[0];
    drop_i   = work && !stale[0] && stale[1];
    want     = work && !(|stale) && (|elig);
    retire   = want && (!h_load[sel] || (resp_valid && opnd_hit));
    resp_pop = want && h_load[sel] && resp_valid;
    dq_pop   = drop_d || (retire && !sel);
    iq_pop   = drop_i || (retire && sel);
    ex_valid   = retire;
    ex_pc      = h_pc[sel];
    ex_operand = h_load[sel] ? opnd_word : '0;
    ext_ev   = (retire || halted) && (ext_irq || ext_ctl_chg);
    restart  = (retire && ((ex_next_pc != h_spc[sel]) || ex_ctl_wr)) || ext_ev;
    new_pc   = retire ? ex_next_pc : pc_q;
    adopt    = retire && (h_gen[sel] != lgen_q);
    if (drop_d && h_auto[0])           src = SRC_UNDO0;
    else if (drop_i && h_auto[1])      src = SRC_UNDO1;
    else if (retire && h_store[sel])   src = SRC_STORE;
    else                               src = SRC_NONE;
    wr_en = (src != SRC_NONE);
    case (src)
      SRC_UNDO0: begin
        wr_addr = h_ptr[0];
        wr_data = h_fin[0][DATA_W-1:0] - DATA_W'(1);
      end
      SRC_UNDO1: begin
        wr_addr = h_ptr[1];
        wr_data = h_fin[1][DATA_W-1:0] - DATA_W'(1);
      end
      SRC_STORE: begin
        wr_addr = h_fin[sel];
        wr_data = ex_store_data;
      end
      default: begin
        wr_addr = '0;
        wr_data = '0;
      end
    endcase
  end

  rc_cmd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      lgen_q      <= '0;
      pc_q        <= RESET_PC;
      redir_valid <= 1'b0;
      redir_pc    <= RESET_PC;
      redir_irq   <= 1'b0;
    end else begin
      if (retire) begin
        cnt_q <= cnt_q + SEQ_W'(1);
        pc_q  <= new_pc;
      end
      if (restart)    lgen_q <= glob_gen + GEN_W'(1);
      else if (adopt) lgen_q <= glob_gen;
      redir_valid <= restart;
      redir_irq   <= ext_ev && ext_irq;
      if (restart) redir_pc <= new_pc;
    end
  end

  assign retire_cnt = cnt_q;

  // R1: halt freezes retirement
  a_r1_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(retire_cnt));
  // R2: only the head matching the count retires
  a_r2_seq_match: assert property (@(posedge clk) disable iff (rst)
    ex_valid |-> ((iq_pop ? iq_seq : dq_seq) == retire_cnt));
  // R3: never two heads consumed at once
  a_r3_one_pop: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dq_pop, iq_pop}));
  // R7: control register write forces restart
  a_r7_ctl_redirect: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_ctl_wr) |=> redir_valid);
  // R9: one step per retirement
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    ex_valid |=> (retire_cnt == $past(retire_cnt) + SEQ_W'(1)));
  // R10: blocked command port means no command next cycle
  a_r10_ready_gate: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> !cmd_valid);
endmodule

// File: tb/sim_retire_ctl.sv
module sim_retire_ctl;
  localparam int PERIOD = 10;
  localparam int NCYC   = 6000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halted, cmd_ready;
  logic [3:0] glob_gen;
  logic dq_valid, dq_load, dq_store, dq_autoinc;
  logic [3:0] dq_gen;
  logic [15:0] dq_seq;
  logic [14:0] dq_pc, dq_seq_pc, dq_fin, dq_ptr;
  logic iq_valid, iq_load, iq_store, iq_autoinc;
  logic [3:0] iq_gen;
  logic [15:0] iq_seq;
  logic [14:0] iq_pc, iq_seq_pc, iq_fin, iq_ptr;
  logic resp_valid;
  logic [11:0] resp_line;
  logic [95:0] resp_data;
  logic [11:0] rw [8];
  logic dq_pop, iq_pop, resp_pop, ex_valid;
  logic [14:0] ex_pc, ex_next_pc;
  logic [11:0] ex_operand, ex_store_data;
  logic ex_ctl_wr, ext_irq, ext_ctl_chg;
  logic cmd_valid, redir_valid, redir_irq;
  logic [14:0] cmd_addr, redir_pc;
  logic [11:0] cmd_data;
  logic [15:0] retire_cnt;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [14:0] ref_next(input logic [14:0] pc, input logic [11:0] op);
    return (pc[2:0] == 3'd5) ? {pc[14:12], op} : pc + 15'd1;
  endfunction

  assign ex_next_pc    = ref_next(ex_pc, ex_operand);
  assign ex_ctl_wr     = (ex_pc[3:0] == 4'hB);
  assign ex_store_data = ex_operand ^ 12'h5A5;
  always_comb for (int k = 0; k < 8; k++) resp_data[k*12 +: 12] = rw[k];

  retire_ctl u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_cnt;
  logic [3:0]  m_lg, m_gg;
  logic [14:0] m_pc;
  logic e_cmd_v, e_rv, e_rirq;
  logic [14:0] e_cmd_a, e_rpc;
  logic [11:0] e_cmd_d;
  string e_cmd_tag;
  bit bump;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pick_gen();
    int r = $urandom % 5;
    logic [3:0] g;
    if (r < 2) return m_lg;
    if (r < 4) return m_gg;
    g = m_gg + 4'd3;
    while (g == m_lg || g == m_gg) g = g + 4'd1;
    return g;
  endfunction

  task automatic drive(input int cyc);
    dq_valid = ($urandom % 10) < 7;
    dq_gen = pick_gen();
    dq_seq = (($urandom % 10) < 6) ? m_cnt : m_cnt + 16'd1;
    dq_pc = 15'($urandom);
    dq_seq_pc = (($urandom % 4) != 0) ? dq_pc + 15'd1 : 15'($urandom);
    dq_load = ($urandom % 10) < 4;
    dq_store = ($urandom % 10) < 4;
    dq_autoinc = ($urandom % 10) < 3;
    dq_fin = 15'($urandom);
    dq_ptr = 15'($urandom);
    iq_valid = ($urandom % 10) < 7;
    iq_gen = pick_gen();
    iq_seq = (($urandom % 10) < 5) ? m_cnt : m_cnt + 16'd2;
    iq_pc = 15'($urandom);
    iq_seq_pc = (($urandom % 4) != 0) ? iq_pc + 15'd1 : 15'($urandom);
    iq_load = ($urandom % 10) < 5;
    iq_store = ($urandom % 10) < 4;
    iq_autoinc = ($urandom % 10) < 3;
    iq_fin = 15'($urandom);
    iq_ptr = 15'($urandom);
    resp_valid = ($urandom % 10) < 6;
    case ($urandom % 5)
      0, 1: resp_line = dq_fin[14:3];
      2, 3: resp_line = iq_fin[14:3];
      default: resp_line = 12'($urandom);
    endcase
    for (int k = 0; k < 8; k++) rw[k] = 12'($urandom);
    cmd_ready = ($urandom % 100) < 85;
    halted = (cyc >= 2000 && cyc < 2100) || (($urandom % 100) < 4);
    ext_irq = ($urandom % 100) < 4;
    ext_ctl_chg = ($urandom % 100) < 4;
    bump = ($urandom % 100) < 4;
    glob_gen = m_gg;
  endtask

  task automatic model_step();
    bit st0, st1, work, el0, el1, ret, ev, rs;
    bit p_d, p_i, p_r, use_i;
    logic [3:0] c_gen;
    logic [14:0] c_pc, c_spc, c_fin, nxt, npc;
    logic c_load, c_store;
    logic [11:0] opnd;
    p_d = 0; p_i = 0; p_r = 0; ret = 0; use_i = 0; opnd = '0;
    c_gen = '0; c_pc = '0; c_spc = '0; c_fin = '0; c_load = 0; c_store = 0;
    e_cmd_v = 0; e_cmd_a = '0; e_cmd_d = '0; e_cmd_tag = "";
    st0 = dq_valid && dq_gen != m_lg && dq_gen != m_gg;
    st1 = iq_valid && iq_gen != m_lg && iq_gen != m_gg;
    work = cmd_ready && !halted;
    if (work) begin
      if (st0) begin
        p_d = 1;
        if (dq_autoinc) begin
          e_cmd_v = 1; e_cmd_a = dq_ptr; e_cmd_d = dq_fin[11:0] - 12'd1;
          e_cmd_tag = "R4 unstore of dropped decode head";
        end
      end else if (st1) begin
        p_i = 1;
        if (iq_autoinc) begin
          e_cmd_v = 1; e_cmd_a = iq_ptr; e_cmd_d = iq_fin[11:0] - 12'd1;
          e_cmd_tag = "R4 unstore of dropped indirect head";
        end
      end else begin
        el0 = dq_valid && dq_seq == m_cnt;
        el1 = iq_valid && iq_seq == m_cnt;
        if (el0 || el1) begin
          use_i = !el0;
          c_gen = use_i ? iq_gen : dq_gen;
          c_pc = use_i ? iq_pc : dq_pc;
          c_spc = use_i ? iq_seq_pc : dq_seq_pc;
          c_fin = use_i ? iq_fin : dq_fin;
          c_load = use_i ? iq_load : dq_load;
          c_store = use_i ? iq_store : dq_store;
          if (c_load) begin
            if (resp_valid) begin
              p_r = 1;
              if (resp_line == c_fin[14:3]) begin
                ret = 1; opnd = rw[c_fin[2:0]];
              end
            end
          end else ret = 1;
          if (ret) begin
            if (use_i) p_i = 1; else p_d = 1;
          end
        end
      end
    end
    chk("R2/R3/R1/R10 dq_pop", dq_pop, p_d);
    chk("R2/R3/R1/R10 iq_pop", iq_pop, p_i);
    chk("R5 resp_pop", resp_pop, p_r);
    chk("R2 ex_valid", ex_valid, ret);
    if (ret) begin
      chk("R2 ex_pc", ex_pc, c_pc);
      chk("R5 ex_operand", ex_operand, opnd);
    end
    nxt = ref_next(c_pc, opnd);
    ev = (ret || halted) && (ext_irq || ext_ctl_chg);
    rs = (ret && (nxt != c_spc || c_pc[3:0] == 4'hB)) || ev;
    npc = ret ? nxt : m_pc;
    if (ret && c_store) begin
      e_cmd_v = 1; e_cmd_a = c_fin; e_cmd_d = opnd ^ 12'h5A5;
      e_cmd_tag = "R6 store command";
    end
    e_rv = rs; e_rirq = ev && ext_irq;
    if (rs) e_rpc = npc;
    if (rs) m_lg = m_gg + 4'd1;
    else if (ret && c_gen != m_lg) m_lg = m_gg;   // R8
    m_gg = m_gg + (rs ? 4'd1 : 4'd0) + (bump ? 4'd1 : 4'd0);
    if (ret) begin
      m_cnt = m_cnt + 16'd1;
      m_pc = npc;
    end
  endtask

  task automatic check_regs();
    chk("R9 retire_cnt", retire_cnt, m_cnt);
    chk("R10/R4/R6 cmd_valid", cmd_valid, e_cmd_v);
    if (e_cmd_v) begin
      chk({e_cmd_tag, " addr"}, cmd_addr, e_cmd_a);
      chk({e_cmd_tag, " data"}, cmd_data, e_cmd_d);
    end
    chk("R7 redir_valid (R8 generation)", redir_valid, e_rv);
    if (e_rv) begin
      chk("R7 redir_pc", redir_pc, e_rpc);
      chk("R7 redir_irq", redir_irq, e_rirq);
    end
  endtask

  initial begin
    m_cnt = '0; m_lg = '0; m_gg = '0; m_pc = 15'h80;
    e_cmd_v = 0; e_rv = 0; e_rirq = 0; e_rpc = 15'h80;
    e_cmd_a = '0; e_cmd_d = '0; e_cmd_tag = "";
    drive(0);
    halted = 1'b0; cmd_ready = 1'b0; dq_valid = 0; iq_valid = 0; resp_valid = 0;
    ext_irq = 0; ext_ctl_chg = 0; bump = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset retire_cnt", retire_cnt, 16'd0);
    chk("R6 reset cmd_valid", cmd_valid, 1'b0);
    chk("R7 reset redir_valid", redir_valid, 1'b0);
    for (int c = 1; c <= NCYC; c++) begin
      drive(c);
      #1;
      model_step();
      @(negedge clk);
      check_regs();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule